// File: doc/BRIEF.md
# DRAM Bank Timing State Tracker

This block keeps the timing state of every bank in a small DRAM channel with several ranks. Each cycle it says whether a proposed command to a given rank and bank would meet the timing rules. A memory controller's scheduler uses it to choose among pending commands. The scheduler presents a candidate on the query port and gets back a legal flag and a row-hit flag. It then drives the command it actually issues on the command port, and the tracker updates its state from that command.

The tracker enforces five kinds of limit, all set as parameters in controller cycles:
- the sensing delay between opening a row and the first column access;
- the restore time before a row may be closed;
- the precharge recovery time before a bank may be opened again;
- a rolling window that allows only a fixed number of row opens per rank;
- the spacing of data bursts on the shared data bus, with extra turnaround time when consecutive bursts come from different ranks.

It also marks the cycle in which read data is due on the bus. A command that breaks a rule is flagged, and it changes no state.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank is closed, `open_valid` and `open_rows` are zero, `cmd_err` and `rd_data_due` are low, an ACT query to any bank is legal and a RD, WR or PRE query is not. Command and query type codes are 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE. A NOP query is never legal.
- R2: ACT is legal only on a closed bank. It must come at least T_RP cycles after that bank's last PRE. It opens the bank with the row given on `cmd_row`.
- R3: RD and WR are legal only on an open bank. They must come at least T_RCD cycles after that bank's ACT.
- R4: PRE is legal only on an open bank. It must come at least T_RAS cycles after that bank's ACT. It closes the bank.
- R5: A rank accepts at most ACT_MAX ACT commands in any T_FAW consecutive cycles. A further ACT inside that window is illegal.
- R6: Two column commands to the same rank must be at least T_BURST cycles apart. If they go to different ranks, the gap must be at least T_BURST+T_RTRS cycles. This holds whichever bank each command targets.
- R7: `rd_data_due` is high exactly T_CAS cycles after each legal RD.
- R8: `qry_row_hit` is high exactly when the queried bank is open and its open row equals `qry_row`.
- R9: A non-NOP command that is illegal raises `cmd_err` in the same cycle, and it leaves all bank, window and bus state unchanged.
- R10: The bit of `open_valid` at index rank*NB+bank shows whether that bank is open. The field of `open_rows` at the same index, ROW_W bits wide, holds its open row, or zero when the bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_type | input | 3 | Type of the command issued this cycle |
| cmd_rank | input | RK_W | Rank of the issued command |
| cmd_bank | input | BK_W | Bank of the issued command |
| cmd_row | input | ROW_W | Row opened by an issued ACT |
| qry_type | input | 3 | Type of the proposed command |
| qry_rank | input | RK_W | Rank of the proposed command |
| qry_bank | input | BK_W | Bank of the proposed command |
| qry_row | input | ROW_W | Row compared for the hit flag |
| qry_legal | output | 1 | The proposed command would be legal this cycle |
| qry_row_hit | output | 1 | The queried bank holds `qry_row` open |
| cmd_err | output | 1 | The issued command is illegal and was dropped |
| rd_data_due | output | 1 | Read data is due on the bus in this cycle |
| open_valid | output | NR*NB | Open flag of each bank |
| open_rows | output | NR*NB*ROW_W | Open row of each bank |

## Verification
`qry_legal`, `qry_row_hit` and `cmd_err` are combinational from the present state and inputs, so they are due in the same cycle as the stimulus. The bench drives inputs at the falling edge and samples these outputs shortly after. `open_valid` and `open_rows` change at the rising edge that ends the command's cycle, so the bench checks them in the following cycle. `rd_data_due` is due T_CAS cycles after the RD. The bench's model keeps a per-cycle history of read issues and indexes it at that distance. All timing limits are checked by cycle-count differences in the bench model, so a rule that is off by one cycle shows as a mismatch at the exact boundary cycle.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;
endpackage

// File: rtl/dbt_bank.sv
// One bank: open flag, open row and its three timing down-counters.
module dbt_bank #(
  parameter int ROW_W = 8,
  parameter int T_RCD = 3,
  parameter int T_RAS = 7,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic             pre_fire,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_ok,
  output logic             ras_ok,
  output logic             rp_ok
);
  localparam int TMAX = (T_RAS > T_RCD) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                        : ((T_RCD > T_RP) ? T_RCD : T_RP);
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] RAS_LD = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [CW-1:0]    rcd_q, rcd_d, ras_q, ras_d, rp_q, rp_d;

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    rcd_d  = (rcd_q != '0) ? rcd_q - 1'b1 : '0;
    ras_d  = (ras_q != '0) ? ras_q - 1'b1 : '0;
    rp_d   = (rp_q  != '0) ? rp_q  - 1'b1 : '0;
    if (act_fire) begin
      open_d = 1'b1;
      row_d  = row_in;
      rcd_d  = RCD_LD;
      ras_d  = RAS_LD;
    end
    if (pre_fire) begin
      open_d = 1'b0;
      rp_d   = RP_LD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rp_q   <= '0;
    end else begin
      open_q <= open_d;
      row_q  <= row_d;
      rcd_q  <= rcd_d;
      ras_q  <= ras_d;
      rp_q   <= rp_d;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign rcd_ok = (rcd_q == '0);
  assign ras_ok = (ras_q == '0);
  assign rp_ok  = (rp_q == '0);

  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> (!open_q && rp_q == '0)); // R2
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> (open_q && row_q == $past(row_in))); // R2
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |=> !open_q); // R4
endmodule

// File: rtl/dbt_faw.sv
// Per-rank rolling activate window: ACT_MAX slots, each counting down from T_FAW-1.
module dbt_faw #(
  parameter int T_FAW   = 12,
  parameter int ACT_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_fire,
  output logic act_ok
);
  localparam int FW = $clog2(T_FAW + 1);
  localparam logic [FW-1:0] FAW_LD = FW'(T_FAW - 1);

  logic [FW-1:0] slot_q [ACT_MAX];
  logic [FW-1:0] slot_d [ACT_MAX];
  logic          placed;

  always_comb begin
    placed = 1'b0;
    for (int s = 0; s < ACT_MAX; s++) begin
      slot_d[s] = (slot_q[s] != '0) ? slot_q[s] - 1'b1 : '0;
      if (act_fire && !placed && slot_q[s] == '0) begin
        slot_d[s] = FAW_LD;
        placed    = 1'b1;
      end
    end
  end

  always_comb begin
    act_ok = 1'b0;
    for (int s = 0; s < ACT_MAX; s++) begin
      if (slot_q[s] == '0) act_ok = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < ACT_MAX; s++) slot_q[s] <= '0;
    end else begin
      for (int s = 0; s < ACT_MAX; s++) slot_q[s] <= slot_d[s];
    end
  end

  AST_FAW_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> act_ok); // R5
endmodule

// File: rtl/dbt_legal.sv
// Combines the status flags of one target bank into a legal flag.
module dbt_legal
  import dbt_pkg::*;
(
  input  logic [2:0] typ,
  input  logic       bank_open,
  input  logic       rcd_ok,
  input  logic       ras_ok,
  input  logic       rp_ok,
  input  logic       faw_ok,
  input  logic       bus_ok,
  output logic       legal
);
  always_comb begin
    case (typ)
      CMD_ACT:         legal = !bank_open && rp_ok && faw_ok;
      CMD_RD, CMD_WR:  legal = bank_open && rcd_ok && bus_ok;
      CMD_PRE:         legal = bank_open && ras_ok;
      default:         legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dbt_pkg::*;
#(
  parameter int NR      = 2,
  parameter int NB      = 8,
  parameter int ROW_W   = 8,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 7,
  parameter int T_RP    = 3,
  parameter int T_CAS   = 4,
  parameter int T_BURST = 4,
  parameter int T_RTRS  = 2,
  parameter int T_FAW   = 12,
  parameter int ACT_MAX = 4,
  localparam int RK_W   = (NR > 1) ? $clog2(NR) : 1,
  localparam int BK_W   = (NB > 1) ? $clog2(NB) : 1,
  localparam int NBK    = NR * NB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             cmd_type,
  input  logic [RK_W-1:0]        cmd_rank,
  input  logic [BK_W-1:0]        cmd_bank,
  input  logic [ROW_W-1:0]       cmd_row,
  input  logic [2:0]             qry_type,
  input  logic [RK_W-1:0]        qry_rank,
  input  logic [BK_W-1:0]        qry_bank,
  input  logic [ROW_W-1:0]       qry_row,
  output logic                   qry_legal,
  output logic                   qry_row_hit,
  output logic                   cmd_err,
  output logic                   rd_data_due,
  output logic [NBK-1:0]         open_valid,
  output logic [NBK*ROW_W-1:0]   open_rows
);
  // NR and NB are powers of two, so {rank,bank} indexes the bank arrays.
  localparam int IDX_W = RK_W + BK_W;
  localparam int BUS_W = $clog2(T_BURST + T_RTRS + 1);
  localparam logic [BUS_W-1:0] SAME_LD  = BUS_W'(T_BURST - 1);
  localparam logic [BUS_W-1:0] OTHER_LD = BUS_W'(T_BURST + T_RTRS - 1);

  logic [IDX_W-1:0] cidx, qidx;
  assign cidx = {cmd_rank, cmd_bank};
  assign qidx = {qry_rank, qry_bank};

  logic [NBK-1:0]   bk_open, bk_rcd_ok, bk_ras_ok, bk_rp_ok;
  logic [NBK-1:0]   act_fire_v, pre_fire_v;
  logic [ROW_W-1:0] bk_row [NBK];
  logic [NR-1:0]    rk_faw_ok;

  logic cmd_ok, col_fire, rd_fire;
  logic cmd_bus_ok, qry_bus_ok;

  logic [BUS_W-1:0] bus_same_q, bus_same_d, bus_other_q, bus_other_d;
  logic [RK_W-1:0]  last_rank_q, last_rank_d;
  logic [T_CAS-1:0] rd_pipe_q, rd_pipe_d;

  // Per-bank state
  for (genvar i = 0; i < NBK; i++) begin : g_bank
    dbt_bank #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_fire (act_fire_v[i]),
      .pre_fire (pre_fire_v[i]),
      .row_in   (cmd_row),
      .open_o   (bk_open[i]),
      .row_o    (bk_row[i]),
      .rcd_ok   (bk_rcd_ok[i]),
      .ras_ok   (bk_ras_ok[i]),
      .rp_ok    (bk_rp_ok[i])
    );
    assign act_fire_v[i] = cmd_ok && (cmd_type == CMD_ACT) && (cidx == IDX_W'(i));
    assign pre_fire_v[i] = cmd_ok && (cmd_type == CMD_PRE) && (cidx == IDX_W'(i));
    assign open_valid[i] = bk_open[i];
    assign open_rows[i*ROW_W +: ROW_W] = bk_open[i] ? bk_row[i] : '0;
  end

  // Per-rank activate window
  for (genvar r = 0; r < NR; r++) begin : g_rank
    dbt_faw #(.T_FAW(T_FAW), .ACT_MAX(ACT_MAX)) u_faw (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_fire (|act_fire_v[r*NB +: NB]),
      .act_ok   (rk_faw_ok[r])
    );
  end

  // Shared data bus spacing
  assign cmd_bus_ok = (cmd_rank == last_rank_q) ? (bus_same_q == '0) : (bus_other_q == '0);
  assign qry_bus_ok = (qry_rank == last_rank_q) ? (bus_same_q == '0) : (bus_other_q == '0);

  dbt_legal u_cmd_chk (
    .typ       (cmd_type),
    .bank_open (bk_open[cidx]),
    .rcd_ok    (bk_rcd_ok[cidx]),
    .ras_ok    (bk_ras_ok[cidx]),
    .rp_ok     (bk_rp_ok[cidx]),
    .faw_ok    (rk_faw_ok[cmd_rank]),
    .bus_ok    (cmd_bus_ok),
    .legal     (cmd_ok)
  );

  dbt_legal u_qry_chk (
    .typ       (qry_type),
    .bank_open (bk_open[qidx]),
    .rcd_ok    (bk_rcd_ok[qidx]),
    .ras_ok    (bk_ras_ok[qidx]),
    .rp_ok     (bk_rp_ok[qidx]),
    .faw_ok    (rk_faw_ok[qry_rank]),
    .bus_ok    (qry_bus_ok),
    .legal     (qry_legal)
  );

  assign cmd_err     = (cmd_type != CMD_NOP) && !cmd_ok;
  assign qry_row_hit = bk_open[qidx] && (bk_row[qidx] == qry_row);
  assign col_fire    = cmd_ok && ((cmd_type == CMD_RD) || (cmd_type == CMD_WR));
  assign rd_fire     = cmd_ok && (cmd_type == CMD_RD);

  always_comb begin
    bus_same_d  = (bus_same_q  != '0) ? bus_same_q  - 1'b1 : '0;
    bus_other_d = (bus_other_q != '0) ? bus_other_q - 1'b1 : '0;
    last_rank_d = last_rank_q;
    if (col_fire) begin
      bus_same_d  = SAME_LD;
      bus_other_d = OTHER_LD;
      last_rank_d = cmd_rank;
    end
    for (int k = T_CAS - 1; k > 0; k--) rd_pipe_d[k] = rd_pipe_q[k-1];
    rd_pipe_d[0] = rd_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_same_q  <= '0;
      bus_other_q <= '0;
      last_rank_q <= '0;
      rd_pipe_q   <= '0;
    end else begin
      bus_same_q  <= bus_same_d;
      bus_other_q <= bus_other_d;
      last_rank_q <= last_rank_d;
      rd_pipe_q   <= rd_pipe_d;
    end
  end

  assign rd_data_due = rd_pipe_q[T_CAS-1];

  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> ($stable(open_valid) && $stable(open_rows))); // R9
  AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    col_fire |-> (bk_open[cidx] && bk_rcd_ok[cidx])); // R3
  AST_ONE_HOT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_fire_v, pre_fire_v})); // R9
  if (T_BURST > 1) begin : g_gap_chk
    AST_BUS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      col_fire |=> !col_fire); // R6
  end
endmodule

// File: tb/test_dram_bank_tracker.sv
module test_dram_bank_tracker;
  localparam int NR = 2, NB = 8, ROW_W = 8, NBK = NR * NB;
  localparam int T_RCD = 3, T_RAS = 7, T_RP = 3, T_CAS = 4;
  localparam int T_BURST = 4, T_RTRS = 2, T_FAW = 12, ACT_MAX = 4;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cmd_type, qry_type;
  logic [0:0] cmd_rank, qry_rank;
  logic [2:0] cmd_bank, qry_bank;
  logic [ROW_W-1:0] cmd_row, qry_row;
  logic qry_legal, qry_row_hit, cmd_err, rd_data_due;
  logic [NBK-1:0] open_valid;
  logic [NBK*ROW_W-1:0] open_rows;

  always #10 clk = ~clk;  // 50 MHz

  dram_bank_tracker i_dram_bank_tracker (
    .clk(clk), .rst_n(rst_n),
    .cmd_type(cmd_type), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .qry_type(qry_type), .qry_rank(qry_rank), .qry_bank(qry_bank), .qry_row(qry_row),
    .qry_legal(qry_legal), .qry_row_hit(qry_row_hit), .cmd_err(cmd_err),
    .rd_data_due(rd_data_due), .open_valid(open_valid), .open_rows(open_rows)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  // Reference model
  bit               m_open [NBK];
  logic [ROW_W-1:0] m_row  [NBK];
  int               m_act_t [NBK];
  int               m_pre_t [NBK];
  int               m_faw [NR][ACT_MAX];
  int               m_last_col = -1000;
  int               m_last_rank = 0;
  bit [31:0]        m_rd_hist = '0;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit m_legal(int t, int r, int b);
    int i;
    int n;
    i = r * NB + b;
    case (t)
      ACT: begin
        n = 0;
        for (int s = 0; s < ACT_MAX; s++) if (cyc - m_faw[r][s] < T_FAW) n++;
        return !m_open[i] && (cyc - m_pre_t[i] >= T_RP) && (n < ACT_MAX);
      end
      RD, WR:
        return m_open[i] && (cyc - m_act_t[i] >= T_RCD) &&
               (cyc - m_last_col >= ((r == m_last_rank) ? T_BURST : T_BURST + T_RTRS));
      PRE: return m_open[i] && (cyc - m_act_t[i] >= T_RAS);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(int t);
    case (t)
      ACT:     return "R2/R5 act legality";
      RD, WR:  return "R3/R6 column legality";
      PRE:     return "R4 pre legality";
      default: return "R1 nop query";
    endcase
  endfunction

  function automatic logic [127:0] m_rows();
    logic [127:0] v = '0;
    for (int i = 0; i < NBK; i++) if (m_open[i]) v[i*ROW_W +: ROW_W] = m_row[i];
    return v;
  endfunction

  function automatic logic [127:0] m_valid();
    logic [127:0] v = '0;
    for (int i = 0; i < NBK; i++) v[i] = m_open[i];
    return v;
  endfunction

  // One cycle: called at a falling edge, returns at the next falling edge.
  task automatic step(int ct, int cr, int cb, int crow, int qt, int qr, int qb, int qrow);
    bit cl, ql, hit, due;
    int ci, qi;
    cmd_type = 3'(ct); cmd_rank = 1'(cr); cmd_bank = 3'(cb); cmd_row = ROW_W'(crow);
    qry_type = 3'(qt); qry_rank = 1'(qr); qry_bank = 3'(qb); qry_row = ROW_W'(qrow);
    #2;
    ci = cr * NB + cb;
    qi = qr * NB + qb;
    cl = m_legal(ct, cr, cb);
    ql = m_legal(qt, qr, qb);
    hit = m_open[qi] && (m_row[qi] == ROW_W'(qrow));
    due = m_rd_hist[T_CAS-1];
    chk(cmd_err == (ct != NOP && !cl), "R9 cmd_err", cmd_err, (ct != NOP && !cl));
    chk(qry_legal == ql, tag_of(qt), qry_legal, ql);
    chk(qry_row_hit == hit, "R8 row hit", qry_row_hit, hit);
    chk(rd_data_due == due, "R7 read data due", rd_data_due, due);
    chk(open_valid == m_valid()[NBK-1:0], "R10 open_valid", open_valid, m_valid());
    chk(open_rows == m_rows(), "R10 open_rows", open_rows, m_rows());
    @(posedge clk);
    if (cl) begin
      case (ct)
        ACT: begin
          m_open[ci] = 1'b1; m_row[ci] = ROW_W'(crow); m_act_t[ci] = cyc;
          begin : place
            for (int s = 0; s < ACT_MAX; s++)
              if (cyc - m_faw[cr][s] >= T_FAW) begin m_faw[cr][s] = cyc; disable place; end
          end
        end
        RD, WR: begin m_last_col = cyc; m_last_rank = cr; end
        PRE: begin m_open[ci] = 1'b0; m_pre_t[ci] = cyc; end
        default: ;
      endcase
    end
    m_rd_hist = {m_rd_hist[30:0], (cl && ct == RD)};
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired at cycle %0d actual=1 expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NBK; i++) begin
      m_open[i] = 0; m_row[i] = '0; m_act_t[i] = -1000; m_pre_t[i] = -1000;
    end
    for (int r = 0; r < NR; r++) for (int s = 0; s < ACT_MAX; s++) m_faw[r][s] = -1000;
    rst_n = 1'b0;
    cmd_type = '0; cmd_rank = '0; cmd_bank = '0; cmd_row = '0;
    qry_type = '0; qry_rank = '0; qry_bank = '0; qry_row = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #2;
    chk(open_valid == '0, "R1 reset open_valid", open_valid, 0);
    chk(open_rows == '0, "R1 reset open_rows", open_rows, 0);
    chk(cmd_err == 1'b0, "R1 reset cmd_err", cmd_err, 0);
    chk(rd_data_due == 1'b0, "R1 reset rd_data_due", rd_data_due, 0);
    qry_type = 3'(ACT); qry_rank = 1'b1; qry_bank = 3'd5; #1;
    chk(qry_legal == 1'b1, "R1 reset ACT query", qry_legal, 1);
    qry_type = 3'(RD); #1;
    chk(qry_legal == 1'b0, "R1 reset RD query", qry_legal, 0);
    qry_type = 3'(PRE); #1;
    chk(qry_legal == 1'b0, "R1 reset PRE query", qry_legal, 0);
    @(negedge clk);

    // Directed: ACT then column access at the T_RCD boundary (R3), read latency (R7)
    step(ACT, 0, 0, 8'h15, RD, 0, 0, 8'h15);
    step(RD, 0, 0, 0, RD, 0, 0, 8'h15);   // too early: cmd_err R9
    step(NOP, 0, 0, 0, RD, 0, 0, 8'h15);
    step(RD, 0, 0, 0, PRE, 0, 0, 0);      // legal at T_RCD
    step(RD, 1, 0, 0, WR, 0, 0, 0);       // bus gap R6
    for (int k = 0; k < 8; k++) step(NOP, 0, 0, 0, PRE, 0, 0, 0);
    // Directed: five ACTs to one rank back to back; the fifth breaks R5
    for (int b = 0; b < 5; b++) step(ACT, 1, b, b + 1, ACT, 1, 7, 0);
    for (int k = 0; k < 14; k++) step(NOP, 0, 0, 0, ACT, 1, 7, 0);

    // Constrained random traffic
    for (int n = 0; n < 6000; n++) begin
      int ct, qt;
      ct = ($urandom_range(0, 9) < 3) ? NOP : int'($urandom_range(1, 4));
      qt = int'($urandom_range(0, 4));
      step(ct, int'($urandom_range(0, 1)), int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
           qt, int'($urandom_range(0, 1)), int'($urandom_range(0, 7)), int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule